// File: doc/BRIEF.md
# Restoring Signed-Magnitude Divider

This block divides a double-length signed-magnitude dividend by a single-length signed-magnitude divisor. The dividend's high magnitude and its sign arrive on the accumulator word. Its low magnitude arrives on the MQ input. A start pulse loads the operands. The block then runs one restoring-division step per clock for a fixed number of steps. When it finishes, the quotient is in MQ and the remainder is in the accumulator.

Before any step runs, the divisor is compared with the high dividend magnitude. If the divisor is not strictly larger, the quotient would not fit. In that case the block skips the division, raises a sticky divide-check flag and pulses a halt request for the surrounding control. The accumulator is left as loaded, and MQ keeps its magnitude with the quotient sign applied.

Words are `MAG_W+1` bits wide. The top bit is the sign (1 = negative) and bits `MAG_W-1:0` are the magnitude. The default `MAG_W` is 35.

Top module: `sm_divider`

## Requirements
- R1: On a start where the divisor magnitude is less than or equal to the accumulator magnitude, `divchk_o` goes high, and `halt_o` and `done_o` pulse high for one cycle, all after the start edge. `busy_o` stays low, so no step runs.
- R2: On such a rejected start, `acc_o` equals the loaded accumulator word. `mq_o` keeps the loaded MQ magnitude, and its sign bit (bit `MAG_W`) is the XOR of the divisor sign and the accumulator sign.
- R3: On an accepted start, `mq_o[MAG_W-1:0]` ends as the floor of ({acc magnitude, mq magnitude} / divisor magnitude).
- R4: On an accepted start, `acc_o[MAG_W-1:0]` ends as the remainder of that division, and the partial remainder is always below the divisor.
- R5: After an accepted division, the `acc_o` sign equals the accumulator (dividend) sign, and the `mq_o` sign is the XOR of the divisor and dividend signs.
- R6: `divchk_o` stays set until `clr_i` is high at a clock edge. If a new divide check happens in the same cycle as `clr_i`, the flag stays set.
- R7: `busy_o` is high for exactly `MAG_W` cycles after an accepted start edge. `done_o` is a single-cycle pulse, and it first appears at the edge after the last step (`MAG_W+1` samples after start) and never while `busy_o` is high.
- R8: A start asserted while `busy_o` is high is ignored. The result and the completion time are those of the first operands.
- R9: After reset, `acc_o`, `mq_o`, `busy_o`, `done_o`, `halt_o` and `divchk_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and begin; ignored while busy |
| clr_i | input | 1 | Clear the sticky divide-check flag |
| div_i | input | MAG_W+1 | Divisor, sign and magnitude |
| acc_i | input | MAG_W+1 | Dividend sign and high magnitude |
| mq_i | input | MAG_W | Dividend low magnitude |
| acc_o | output | MAG_W+1 | Remainder / accumulator word |
| mq_o | output | MAG_W+1 | Quotient / MQ word |
| divchk_o | output | 1 | Sticky divide-check flag |
| halt_o | output | 1 | One-cycle halt request on divide check |
| busy_o | output | 1 | Division steps in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the boundary of the pre-check. The stimulus puts an accumulator magnitude exactly equal to the divisor next to one exactly one below it, with the MQ magnitude all ones. The first must be rejected, and the second must produce a quotient of all ones with the largest possible partial remainders.

A second stimulus applies a fresh start in the middle of a busy run, using operands that would give a different answer. This shows the start is ignored. The sticky flag is also driven with a clear on the same edge as a new rejection, to show the set wins.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/sm_div_precheck.sv
module sm_div_precheck #(
  parameter int MAG_W = 35
) (
  input  logic [MAG_W-1:0] div_mag_i,
  input  logic [MAG_W-1:0] hi_mag_i,
  output logic             reject_o
);
  // quotient overflows unless divisor strictly exceeds high dividend
  assign reject_o = (div_mag_i <= hi_mag_i);
endmodule

// File: rtl/sm_div_step.sv
module sm_div_step #(
  parameter int MAG_W = 35
) (
  input  logic [MAG_W-1:0] rem_i,
  input  logic [MAG_W-1:0] quo_i,
  input  logic [MAG_W-1:0] div_i,
  output logic [MAG_W-1:0] rem_o,
  output logic [MAG_W-1:0] quo_o
);
  logic [MAG_W:0] shifted;
  logic [MAG_W:0] diff;
  logic           fits;

  assign shifted = {rem_i, quo_i[MAG_W-1]};
  assign diff    = shifted - {1'b0, div_i};
  assign fits    = (shifted >= {1'b0, div_i});
  assign rem_o   = fits ? diff[MAG_W-1:0] : shifted[MAG_W-1:0];
  assign quo_o   = {quo_i[MAG_W-2:0], fits};
endmodule

// File: rtl/sm_div_counter.sv
module sm_div_counter #(
  parameter int ITERS = 35,
  localparam int CW = $clog2(ITERS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(ITERS - 1));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |-> cnt_q < CW'(ITERS));
endmodule

// File: rtl/sm_divider.sv
module sm_divider
  import sm_div_pkg::*;
#(
  parameter int MAG_W = 35,
  localparam int W = MAG_W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  input  logic [W-1:0] acc_i,
  input  logic [MAG_W-1:0] mq_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mq_o,
  output logic         divchk_o,
  output logic         halt_o,
  output logic         busy_o,
  output logic         done_o
);
  div_state_e       state_q;
  logic [MAG_W-1:0] rem_q, quo_q, dvs_q;
  logic             rem_sgn_q, quo_sgn_q;
  logic             divchk_q, halt_q, done_q;
  logic [MAG_W-1:0] rem_n, quo_n;
  logic             reject, last, accept;

  assign accept = start_i && (state_q == ST_IDLE);

  sm_div_precheck #(.MAG_W(MAG_W)) u_pre (
    .div_mag_i(div_i[MAG_W-1:0]),
    .hi_mag_i (acc_i[MAG_W-1:0]),
    .reject_o (reject)
  );

  sm_div_step #(.MAG_W(MAG_W)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .div_i(dvs_q),
    .rem_o(rem_n),
    .quo_o(quo_n)
  );

  sm_div_counter #(.ITERS(MAG_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .en_i  (state_q == ST_RUN),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      rem_sgn_q <= 1'b0;
      quo_sgn_q <= 1'b0;
      halt_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      halt_q <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        // both paths load identically; reject just never runs
        rem_q     <= acc_i[MAG_W-1:0];
        quo_q     <= mq_i;
        dvs_q     <= div_i[MAG_W-1:0];
        rem_sgn_q <= acc_i[MAG_W];
        quo_sgn_q <= acc_i[MAG_W] ^ div_i[MAG_W];
        if (reject) begin
          halt_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
        end
      end else if (state_q == ST_RUN) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  // sticky flag, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               divchk_q <= 1'b0;
    else if (accept && reject) divchk_q <= 1'b1;
    else if (clr_i)            divchk_q <= 1'b0;
  end

  assign acc_o    = {rem_sgn_q, rem_q};
  assign mq_o     = {quo_sgn_q, quo_q};
  assign divchk_o = divchk_q;
  assign halt_o   = halt_q;
  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;

  p_halt_sets_chk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> divchk_o && done_o && !busy_o);
  p_fail_mq_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> mq_o[MAG_W] == ($past(div_i[MAG_W]) ^ $past(acc_i[MAG_W])));
  p_partial_lt_div_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q < dvs_q);
  p_chk_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    divchk_o && !clr_i |=> divchk_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_signs_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(acc_o[MAG_W]) && $stable(mq_o[MAG_W]));
endmodule

// File: tb/tb_sm_divider.sv
module tb_sm_divider;
  localparam int MAG_W = 35;
  localparam int W = MAG_W + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, clr_i = 1'b0;
  logic [W-1:0] div_i = '0, acc_i = '0;
  logic [MAG_W-1:0] mq_i = '0;
  logic [W-1:0] acc_o, mq_o;
  logic divchk_o, halt_o, busy_o, done_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sm_divider #(.MAG_W(MAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clr_i(clr_i),
    .div_i(div_i), .acc_i(acc_i), .mq_i(mq_i),
    .acc_o(acc_o), .mq_o(mq_o), .divchk_o(divchk_o), .halt_o(halt_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [W-1:0] a, input logic [MAG_W-1:0] m,
                                  input logic [W-1:0] d,
                                  output logic [W-1:0] ea, output logic [W-1:0] em);
    logic [2*MAG_W-1:0] dvd, q, r, dd;
    dvd = {a[MAG_W-1:0], m};
    dd  = {{MAG_W{1'b0}}, d[MAG_W-1:0]};
    q   = dvd / dd;
    r   = dvd % dd;
    ea  = {a[MAG_W], r[MAG_W-1:0]};
    em  = {a[MAG_W] ^ d[MAG_W], q[MAG_W-1:0]};
  endfunction

  // drive a start; return samples until done (1 = done right after start edge)
  task automatic launch(input logic [W-1:0] a, input logic [MAG_W-1:0] m,
                        input logic [W-1:0] d, input bit clr_same, input bit poke,
                        output int cyc, output int busy_cnt);
    @(negedge clk);
    acc_i = a; mq_i = m; div_i = d; start_i = 1'b1; clr_i = clr_same;
    cyc = 0; busy_cnt = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0; clr_i = 1'b0;
      cyc++;
      if (busy_o) busy_cnt++;
      if (poke && cyc == 5) begin
        acc_i = '0; mq_i = 35'd7; div_i = 36'd2; start_i = 1'b1;
      end
    end while (!done_o && cyc < 100);
  endtask

  task automatic t_reset();
    check("R9 acc", acc_o, '0);
    check("R9 mq", mq_o, '0);
    check("R9 flags", {32'd0, divchk_o, halt_o, busy_o, done_o}, '0);
  endtask

  task automatic t_ok(input string tag, input logic [W-1:0] a, input logic [MAG_W-1:0] m,
                      input logic [W-1:0] d);
    logic [W-1:0] ea, em;
    int cyc, bc;
    ref_div(a, m, d, ea, em);
    launch(a, m, d, 1'b0, 1'b0, cyc, bc);
    check({"R3 quotient ", tag}, {1'b0, mq_o[MAG_W-1:0]}, {1'b0, em[MAG_W-1:0]});
    check({"R4 remainder ", tag}, {1'b0, acc_o[MAG_W-1:0]}, {1'b0, ea[MAG_W-1:0]});
    check({"R5 signs ", tag}, W'({acc_o[MAG_W], mq_o[MAG_W]}), W'({ea[MAG_W], em[MAG_W]}));
    check({"R7 done time ", tag}, W'(cyc), W'(MAG_W + 1));
    check({"R7 busy len ", tag}, W'(bc), W'(MAG_W));
    @(negedge clk);
    check({"R7 done pulse ", tag}, W'(done_o), '0);
  endtask

  task automatic t_reject(input string tag, input logic [W-1:0] a, input logic [MAG_W-1:0] m,
                          input logic [W-1:0] d, input bit clr_same);
    int cyc, bc;
    launch(a, m, d, clr_same, 1'b0, cyc, bc);
    check({"R1 done at once ", tag}, W'(cyc), W'(1));
    check({"R1 flags ", tag}, W'({divchk_o, halt_o, busy_o}), W'(3'b110));
    check({"R2 acc kept ", tag}, acc_o, a);
    check({"R2 mq ", tag}, mq_o, {a[MAG_W] ^ d[MAG_W], m});
    @(negedge clk);
    check({"R1 halt pulse ", tag}, W'({halt_o, done_o}), '0);
  endtask

  task automatic t_sticky();
    t_reject("set", 36'd5, 35'd1, 36'd5, 1'b0);
    t_ok("after chk", 36'd0, 35'd9, 36'd4);
    check("R6 sticky through divide", W'(divchk_o), W'(1));
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    check("R6 cleared", W'(divchk_o), '0);
    t_reject("clr same edge", 36'd3, 35'd0, 36'd2, 1'b1);
    check("R6 set wins over clear", W'(divchk_o), W'(1));
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic t_ignore();
    logic [W-1:0] ea, em;
    int cyc, bc;
    ref_div(36'd123, 35'd456789, 36'd1000, ea, em);
    launch(36'd123, 35'd456789, 36'd1000, 1'b0, 1'b1, cyc, bc);
    check("R8 quotient", mq_o, em);
    check("R8 remainder", acc_o, ea);
    check("R8 done time", W'(cyc), W'(MAG_W + 1));
    check("R8 no restart", W'(busy_o), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_ok("pos", 36'd0, 35'd100, 36'd7);
    t_ok("neg dvd", {1'b1, 35'd3}, 35'h123456789, 36'd10);
    t_ok("neg dvs", 36'd1, 35'd0, {1'b1, 35'd3});
    t_ok("both neg", {1'b1, 35'd0}, 35'd12345, {1'b1, 35'd11});
    t_ok("zero", 36'd0, 35'd0, 36'd1);
    t_ok("max", {1'b0, 35'h7fffffffe}, 35'h7ffffffff, {1'b0, 35'h7ffffffff});
    t_reject("equal", {1'b0, 35'd50}, 35'd77, {1'b1, 35'd50}, 1'b0);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    t_reject("less", {1'b1, 35'd9}, 35'd4, {1'b1, 35'd8}, 1'b0);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    t_reject("zero div", 36'd0, 35'd1, {1'b1, 35'd0}, 1'b0);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    t_sticky();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule